// File: doc/BRIEF.md
# Interrupt Active-State Register Bank

This block keeps the active flag of every interrupt that an interrupt distributor handles. Software changes these flags through byte-wide register writes in two windows. A write to the set window raises flags and a write to the clear window lowers them. Each data byte covers eight neighbouring interrupts, and each 1 bit in the byte acts on one of them. Interrupts 0 to 31 are private to each CPU, so the block keeps one 32-bit copy per CPU. Every interrupt above 31 has a single flag that all CPUs share.

The block also enforces access rules. A non-secure writer cannot change a group-0 interrupt while the security extension is on, and the same bits read back as zero to it. Writes are accepted only when the newer revision is selected. A byte that lies above the implemented interrupt count is reported as a bad access. The active vectors leave the block as registered outputs for the priority and forwarding logic around it.

Top module: `irq_active_bank`

## Requirements
- R1: Byte offsets 0x300-0x37F form the set window and 0x380-0x3FF form the clear window. Offset bits [6:0] give the byte number n. Data bit i of byte n acts on interrupt 8*n+i. Interrupts 0-31 appear as bit cpu*32+irq of `act_bank`, and interrupt k≥32 appears as bit k-32 of `act_shr`.
- R2: In a set-window write, each 1 bit sets the addressed active flag. Each 0 bit leaves its flag unchanged. Without a write strobe no flag changes.
- R3: In a clear-window write, each 1 bit clears the addressed active flag. Each 0 bit leaves its flag unchanged.
- R4: A write that targets interrupts below 32 changes only the copy of the CPU given by `acc_cpu`.
- R5: A write that targets interrupts 32 and above changes the single shared flag seen by every CPU.
- R6: When `sec_ext_en`=1 and `acc_secure`=0, a written bit is ignored if its interrupt's group bit for the accessing CPU is 0. The group bits are `grp_bank` bit cpu*32+irq for irq<32 and `grp_shr` bit irq-32 otherwise.
- R7: When `sec_ext_en`=1 and `acc_secure`=0, read data bits for group-0 interrupts are 0.
- R8: If 8*n ≥ NIRQ, a read or write in either window raises `bad_acc`. Such a write changes no flag, and such a read returns 0.
- R9: When `rev_new`=0, writes to either window change nothing and raise `bad_acc`. Reads still work.
- R10: A read in either window returns the eight flags of the addressed byte in the cycle after the read strobe. Interrupts below 32 are taken from the accessing CPU's copy. In every other cycle `rd_data` is 0.
- R11: `bad_acc` is high only in the cycle after a read or write strobe that breaks R8 or R9. Strobes at offsets outside 0x300-0x3FF are ignored and do not raise it.
- R12: A synchronous reset clears all banked and shared flags, `rd_data` and `bad_acc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_off | input | 10 | Byte offset of the register access |
| reg_wdata | input | 8 | Write data byte |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| acc_cpu | input | CPU_W | Number of the accessing CPU |
| acc_secure | input | 1 | 1 = secure access |
| grp_bank | input | NCPU*32 | Per-CPU group bits of interrupts 0-31 (1 = group 1) |
| grp_shr | input | NIRQ-32 | Group bits of interrupts 32 and above |
| sec_ext_en | input | 1 | Security extension enable |
| rev_new | input | 1 | 1 = newer revision, windows writable |
| rd_data | output | 8 | Registered read data |
| bad_acc | output | 1 | One-cycle bad-access pulse |
| act_bank | output | NCPU*32 | Banked active flags, bit cpu*32+irq |
| act_shr | output | NIRQ-32 | Shared active flags, bit irq-32 |

## Verification
The active flags are the block's outputs, so a wrong flag is visible at `act_bank` or `act_shr` one cycle after the write that caused it. The bench compares both vectors with its own model after every access. A byte lane that is misrouted, a mistake in CPU bank selection, or a security filter that fails to block a bit all show up at that point. The read path and the bad-access flag are checked in the cycle after each strobe. Errors in read masking or range decoding therefore appear within one clock of the access.

// File: rtl/irq_act_pkg.sv
package irq_act_pkg;

  // Which window an access falls into (offset bit 7)
  typedef enum logic {
    WIN_SET = 1'b0,
    WIN_CLR = 1'b1
  } win_e;

  typedef struct packed {
    logic       hit;       // offset lies in 0x300..0x3FF
    win_e       win;
    logic [6:0] byte_idx;  // byte n inside the window
  } dec_t;

endpackage

// File: rtl/iab_decode.sv
module iab_decode
  import irq_act_pkg::*;
#(
  parameter int NIRQ = 64
) (
  input  logic [9:0] off,
  output dec_t       dec,
  output logic       in_range
);

  always_comb begin
    dec.hit      = (off[9:8] == 2'b11);
    dec.win      = win_e'(off[7]);
    dec.byte_idx = off[6:0];
    in_range     = (int'(off[6:0]) * 8) < NIRQ;
  end

endmodule

// File: rtl/iab_bank_store.sv
module iab_bank_store
  import irq_act_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  win_e                 win,
  input  logic [1:0]           byte_sel,
  input  logic [CPU_W-1:0]     cpu,
  input  logic [7:0]           mask,
  output logic [NCPU*32-1:0]   act
);

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    logic [31:0] copy_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        copy_q <= '0;
      end else if (wr_en && (cpu == CPU_W'(g))) begin
        if (win == WIN_SET)
          copy_q[{byte_sel, 3'b000} +: 8] <= copy_q[{byte_sel, 3'b000} +: 8] | mask;
        else
          copy_q[{byte_sel, 3'b000} +: 8] <= copy_q[{byte_sel, 3'b000} +: 8] & ~mask;
      end
    end

    assign act[g*32 +: 32] = copy_q;
  end

endmodule

// File: rtl/iab_shared_store.sv
module iab_shared_store
  import irq_act_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int SB_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  win_e                  win,
  input  logic [SB_W-1:0]       byte_sel,
  input  logic [7:0]            mask,
  output logic [NBYTES*8-1:0]   act
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [7:0] lane_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= '0;
      end else if (wr_en && (byte_sel == SB_W'(b))) begin
        if (win == WIN_SET)
          lane_q <= lane_q | mask;
        else
          lane_q <= lane_q & ~mask;
      end
    end

    assign act[b*8 +: 8] = lane_q;
  end

endmodule

// File: rtl/irq_active_bank.sv
module irq_active_bank
  import irq_act_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NIRQ  = 64,
  parameter int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [9:0]           reg_off,
  input  logic [7:0]           reg_wdata,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [CPU_W-1:0]     acc_cpu,
  input  logic                 acc_secure,
  input  logic [NCPU*32-1:0]   grp_bank,
  input  logic [NIRQ-33:0]     grp_shr,
  input  logic                 sec_ext_en,
  input  logic                 rev_new,
  output logic [7:0]           rd_data,
  output logic                 bad_acc,
  output logic [NCPU*32-1:0]   act_bank,
  output logic [NIRQ-33:0]     act_shr
);

  localparam int SHR_BYTES = (NIRQ - 32) / 8;
  localparam int SB_W      = (SHR_BYTES > 1) ? $clog2(SHR_BYTES) : 1;
  localparam int BIDX_W    = CPU_W + 5;

  dec_t            dec;
  logic            in_range;
  logic            banked;
  logic [1:0]      bsel_bank;
  logic [SB_W-1:0] bsel_shr;
  logic [BIDX_W-1:0] bank_base;
  logic [7:0]      grp_byte;
  logic [7:0]      filt;
  logic [7:0]      wmask;
  logic            wr_ok;
  logic            bad_nxt;
  logic [7:0]      rd_raw;
  logic [7:0]      rd_nxt;

  iab_decode #(.NIRQ(NIRQ)) dec_i (
    .off      (reg_off),
    .dec      (dec),
    .in_range (in_range)
  );

  always_comb begin
    banked    = dec.byte_idx < 7'd4;
    bsel_bank = dec.byte_idx[1:0];
    bsel_shr  = (in_range && !banked) ? SB_W'(dec.byte_idx - 7'd4) : '0;
    bank_base = {acc_cpu, bsel_bank, 3'b000};

    grp_byte  = banked ? grp_bank[bank_base +: 8] : grp_shr[{bsel_shr, 3'b000} +: 8];
    // non-secure writer sees only group-1 lanes
    filt      = (sec_ext_en && !acc_secure) ? grp_byte : 8'hFF;
    wmask     = reg_wdata & filt;

    wr_ok     = reg_wr && dec.hit && in_range && rev_new;
    bad_nxt   = dec.hit && (reg_wr || reg_rd) && (!in_range || (reg_wr && !rev_new));

    rd_raw    = banked ? act_bank[bank_base +: 8] : act_shr[{bsel_shr, 3'b000} +: 8];
    rd_nxt    = (reg_rd && dec.hit && in_range) ? (rd_raw & filt) : 8'h00;
  end

  iab_bank_store #(.NCPU(NCPU), .CPU_W(CPU_W)) bank_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_ok && banked),
    .win      (dec.win),
    .byte_sel (bsel_bank),
    .cpu      (acc_cpu),
    .mask     (wmask),
    .act      (act_bank)
  );

  iab_shared_store #(.NBYTES(SHR_BYTES), .SB_W(SB_W)) shr_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_ok && !banked),
    .win      (dec.win),
    .byte_sel (bsel_shr),
    .mask     (wmask),
    .act      (act_shr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      bad_acc <= 1'b0;
    end else begin
      rd_data <= rd_nxt;
      bad_acc <= bad_nxt;
    end
  end

endmodule

// File: rtl/iab_checker.sv
module iab_checker #(
  parameter int NCPU = 4,
  parameter int NIRQ = 64
) (
  input logic               clk,
  input logic               rst,
  input logic [9:0]         reg_off,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic               acc_secure,
  input logic [NCPU*32-1:0] grp_bank,
  input logic [NIRQ-33:0]   grp_shr,
  input logic               sec_ext_en,
  input logic               rev_new,
  input logic [7:0]         rd_data,
  input logic               bad_acc,
  input logic [NCPU*32-1:0] act_bank,
  input logic [NIRQ-33:0]   act_shr
);

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (act_bank == '0 && act_shr == '0 && !bad_acc && rd_data == 8'h00));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> ($stable(act_bank) && $stable(act_shr)));

  // R2
  set_only_raises_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_off[9:7] == 3'b110) |=>
      (((act_bank & $past(act_bank)) == $past(act_bank)) &&
       ((act_shr & $past(act_shr)) == $past(act_shr))));

  // R3
  clr_only_lowers_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_off[9:7] == 3'b111) |=>
      (((act_bank & ~$past(act_bank)) == '0) &&
       ((act_shr & ~$past(act_shr)) == '0)));

  // R6
  group0_shield_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sec_ext_en && !acc_secure && grp_bank == '0 && grp_shr == '0) |=>
      ($stable(act_bank) && $stable(act_shr)));

  // R8
  range_bad_chk: assert property (@(posedge clk) disable iff (rst)
    ((reg_wr || reg_rd) && reg_off[9:8] == 2'b11 && (int'(reg_off[6:0]) * 8) >= NIRQ) |=>
      (bad_acc && rd_data == 8'h00 && $stable(act_bank) && $stable(act_shr)));

  // R9
  old_rev_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !rev_new && reg_off[9:8] == 2'b11) |=>
      (bad_acc && $stable(act_bank) && $stable(act_shr)));

  // R10
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (rd_data == 8'h00));

  // R11
  bad_cause_chk: assert property (@(posedge clk) disable iff (rst)
    bad_acc |-> $past((reg_wr || reg_rd) && reg_off[9:8] == 2'b11));

endmodule

bind irq_active_bank iab_checker #(.NCPU(NCPU), .NIRQ(NIRQ)) chk_i (.*);

// File: tb/irq_active_bank_tb_top.sv
module irq_active_bank_tb_top;

  localparam int NCPU  = 2;
  localparam int NIRQ  = 64;
  localparam int CPU_W = 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [9:0]         reg_off = '0;
  logic [7:0]         reg_wdata = '0;
  logic               reg_wr = 1'b0;
  logic               reg_rd = 1'b0;
  logic [CPU_W-1:0]   acc_cpu = '0;
  logic               acc_secure = 1'b1;
  logic [NCPU*32-1:0] grp_bank = 64'hA5C3_0F96_3C5A_F00F;
  logic [NIRQ-33:0]   grp_shr = 32'h6B2D_91E4;
  logic               sec_ext_en = 1'b0;
  logic               rev_new = 1'b1;
  logic [7:0]         rd_data;
  logic               bad_acc;
  logic [NCPU*32-1:0] act_bank;
  logic [NIRQ-33:0]   act_shr;

  logic [NCPU*32-1:0] m_bank = '0;
  logic [NIRQ-33:0]   m_shr = '0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_active_bank #(.NCPU(NCPU), .NIRQ(NIRQ)) dut_i (.*);

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic grp_of(input int irq, input int cpu);
    return (irq < 32) ? grp_bank[cpu*32 + irq] : grp_shr[irq - 32];
  endfunction

  task automatic check_state(input string tag);
    chk(tag, "act_bank", 64'(act_bank), 64'(m_bank));
    chk(tag, "act_shr",  64'(act_shr),  64'(m_shr));
  endtask

  task automatic wr_op(input logic [9:0] off, input logic [7:0] d, input int cpu,
                       input logic sec, input string tag);
    bit in_win = (off[9:8] == 2'b11);
    int first  = int'(off[6:0]) * 8;
    bit exp_bad = in_win && (first >= NIRQ || !rev_new);
    if (in_win && !exp_bad) begin
      for (int i = 0; i < 8; i++) begin
        int irq = first + i;
        if (d[i] && (!(sec_ext_en && !sec) || grp_of(irq, cpu))) begin
          if (irq < 32) m_bank[cpu*32 + irq] = !off[7];
          else          m_shr[irq - 32]      = !off[7];
        end
      end
    end
    @(negedge clk);
    reg_off = off; reg_wdata = d; acc_cpu = CPU_W'(cpu); acc_secure = sec; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(tag, "bad_acc after write", 64'(bad_acc), 64'(exp_bad));
    check_state(tag);
  endtask

  task automatic rd_op(input logic [9:0] off, input int cpu, input logic sec,
                       input string tag);
    bit in_win = (off[9:8] == 2'b11);
    int first  = int'(off[6:0]) * 8;
    bit exp_bad = in_win && (first >= NIRQ);
    logic [7:0] exp = '0;
    if (in_win && !exp_bad) begin
      for (int i = 0; i < 8; i++) begin
        int irq = first + i;
        logic v = (irq < 32) ? m_bank[cpu*32 + irq] : m_shr[irq - 32];
        if (sec_ext_en && !sec && !grp_of(irq, cpu)) v = 1'b0;
        exp[i] = v;
      end
    end
    @(negedge clk);
    reg_off = off; acc_cpu = CPU_W'(cpu); acc_secure = sec; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, "rd_data", 64'(rd_data), 64'(exp));
    chk(tag, "bad_acc after read", 64'(bad_acc), 64'(exp_bad));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12", "act_bank in reset", 64'(act_bank), 64'h0);
    chk("R12", "act_shr in reset", 64'(act_shr), 64'h0);
    chk("R12", "bad_acc in reset", 64'(bad_acc), 64'h0);
    rst = 1'b0;

    // R1: byte 5 of set window, bit 2 -> interrupt 42 -> act_shr bit 10
    wr_op(10'h305, 8'h04, 0, 1'b1, "R1");
    chk("R1", "irq 42 flag", 64'(act_shr[10]), 64'h1);
    // R2: zero data leaves everything
    wr_op(10'h305, 8'h00, 1, 1'b1, "R2");

    // set sweep over both CPUs, including out-of-range bytes
    for (int c = 0; c < NCPU; c++)
      for (int n = 0; n < 16; n++)
        wr_op(10'h300 + 10'(n), 8'(n*53 + c*29 + 17), c, 1'b1,
              (n < 4) ? "R4" : ((n < 8) ? "R5" : "R8"));
    // read sweep over both windows
    for (int c = 0; c < NCPU; c++)
      for (int n = 0; n < 16; n++) begin
        rd_op(10'h300 + 10'(n), c, 1'b1, (n < 8) ? "R10" : "R8");
        rd_op(10'h380 + 10'(n), c, 1'b1, (n < 8) ? "R10" : "R8");
      end
    // clear sweep
    for (int c = 0; c < NCPU; c++)
      for (int n = 0; n < 8; n++)
        wr_op(10'h380 + 10'(n), 8'(n*71 + c*13 + 5), c, 1'b1, "R3");

    // security filtering
    @(negedge clk); sec_ext_en = 1'b1;
    for (int c = 0; c < NCPU; c++)
      for (int n = 0; n < 8; n++) wr_op(10'h300 + 10'(n), 8'hFF, c, 1'b0, "R6");
    for (int c = 0; c < NCPU; c++)
      for (int n = 0; n < 8; n++) begin
        rd_op(10'h300 + 10'(n), c, 1'b0, "R7");
        rd_op(10'h380 + 10'(n), c, 1'b1, "R10");
      end
    for (int c = 0; c < NCPU; c++)
      for (int n = 0; n < 8; n++) wr_op(10'h380 + 10'(n), 8'hFF, c, 1'b0, "R6");
    for (int c = 0; c < NCPU; c++)
      for (int n = 0; n < 8; n++) wr_op(10'h300 + 10'(n), 8'(n*19 + c*7 + 3), c, 1'b1, "R2");
    @(negedge clk); sec_ext_en = 1'b0;

    // older revision
    @(negedge clk); rev_new = 1'b0;
    for (int n = 0; n < 8; n++) begin
      wr_op(10'h300 + 10'(n), 8'hFF, n % NCPU, 1'b1, "R9");
      wr_op(10'h380 + 10'(n), 8'hFF, n % NCPU, 1'b1, "R9");
      rd_op(10'h300 + 10'(n), n % NCPU, 1'b1, "R9");
    end
    // R11: the bad pulse lasts one cycle
    @(negedge clk);
    chk("R11", "bad_acc one cycle after", 64'(bad_acc), 64'h0);
    @(negedge clk); rev_new = 1'b1;

    // R11: offsets outside the windows are ignored
    wr_op(10'h2FF, 8'hFF, 0, 1'b1, "R11");
    wr_op(10'h000, 8'hFF, 1, 1'b1, "R11");
    rd_op(10'h0FF, 0, 1'b1, "R11");

    // R12: reset from a busy state
    wr_op(10'h300, 8'hFF, 0, 1'b1, "R2");
    wr_op(10'h307, 8'hFF, 1, 1'b1, "R5");
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    m_bank = '0; m_shr = '0;
    check_state("R12");
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule